// File: doc/BRIEF.md
# Cascadable Triple 8-bit Timer

The block holds three 8-bit up-counters. Each has its own compare register, a control register and a match interrupt. Each channel moves forward on a one-cycle count strobe that belongs to that channel. When a strobe finds the counter equal to the compare value, the channel raises its interrupt pulse. Each channel runs in one of two modes. In free-running mode the counter wraps from FFH to 00H. In clear-and-start mode it returns to 00H on a match. A PWM flag stops the interrupt and leaves the counting unchanged.

Two neighbouring channels can be joined into one 16-bit timer. The pairs allowed are (0,1) and (1,2). The higher-numbered channel holds the upper byte of both the count and the compare value. In a pair, the lower channel's strobe drives the count, and the lower channel's mode sets the match behaviour. A 16-bit match pulses the interrupts of both channels in the same cycle. Software uses a small register bus to read the counters and to set the compare and control registers. Reading a counter holds off its count for that cycle, so the value read is stable and no strobe is lost.

Top module: `casc_timer_bank`

## Requirements
- R1: After reset every counter reads 00H, every control register reads 00H (channel disabled), the cascade register reads 00H and every interrupt output is low.
- R2: An enabled channel that gets a count strobe (tick_i[n]=1) shows its counter one higher, modulo 256, in the next cycle. A disabled channel ignores strobes and stays at 00H.
- R3: Clearing a channel's enable bit (control bit 0) clears its counter to 00H.
- R4: A strobe that finds the counter equal to its compare value drives irq_o[n] high in the next cycle. In clear-and-start mode (control bit 1 = 1) that strobe loads 00H. In free-running mode it counts on as usual, with FFH wrapping to 00H.
- R5: With the PWM flag (control bit 2) set, the channel never raises its interrupt, and its counting is unchanged.
- R6: Each interrupt is a pulse one cycle long.
- R7: With cascade bit 0 set, channels 0 and 1 form one 16-bit counter, with channel 1 as the upper byte. Channel 1 advances only when channel 0 rolls over from FFH on a strobe. A match is tested on all 16 bits and raises irq_o[0] and irq_o[1] in the same cycle. Channel 0's mode sets whether the match clears both bytes. Channel 1's own strobe is ignored.
- R8: In a cascaded pair, clearing the enable bit of either channel clears both bytes to 00H.
- R9: With both cascade bits set, the pair (0,1) is used and channel 2 counts as an independent 8-bit timer.
- R10: With cascade bit 1 alone set, channels 1 and 2 form the 16-bit pair, with channel 2 as the upper byte and irq_o[1] and irq_o[2] pulsing together on a match.
- R11: A read returns data on rdata_o one cycle after rd_en_i. A counter read returns the count of that cycle. A strobe that arrives during the read is delayed by one cycle and still counted.
- R12: A compare register can be rewritten while its channel counts, and the new value is used from the next strobe on. Address map: counter n at n, compare n at 4+n, control n at 8+n, cascade at 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 3 | Per-channel count strobe, one cycle per count edge |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one cycle after rd_en_i |
| irq_o | output | 3 | Per-channel match interrupt pulse |

## Verification
The hardest cases to reach are the ones that depend on a long count: the carry from the lower byte into the upper byte in a pair, and a 16-bit match that has to fire both interrupts in the same cycle. The stimulus sets 16-bit compare values just above 0100H. It then sends a few hundred back-to-back strobes on the lower channel, with the upper channel's own strobe also driven, to show that it is ignored. The delayed strobe during a read is produced by raising a strobe and a counter read in the same cycle, then reading the counter again.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NCH    = 3;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 4;

  // address groups, selected by addr[ADDR_W-1:2]
  localparam int G_CNT = 0;
  localparam int G_CMP = 1;
  localparam int G_CTL = 2;
  localparam int G_CAS = 3;

  typedef struct packed {
    logic pwm;       // bit 2
    logic clr_mode;  // bit 1
    logic en;        // bit 0
  } chan_ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int N  = NCH,
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      cnt_i  [N],
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      cmp_o  [N],
  output chan_ctrl_t        ctl_o  [N],
  output logic [1:0]        casc_o,
  output logic [N-1:0]      rd_hit_o
);
  localparam int GW = AW - 2;

  logic [GW-1:0] grp;
  logic [1:0]    idx;
  assign grp = addr_i[AW-1:2];
  assign idx = addr_i[1:0];

  for (genvar c = 0; c < N; c++) begin : g_reg
    logic sel;
    assign sel = (idx == 2'(c));
    assign rd_hit_o[c] = rd_en_i && (grp == GW'(G_CNT)) && sel;

    // compare value has no reset value; software loads it before use
    always_ff @(posedge clk_i) begin
      if (wr_en_i && grp == GW'(G_CMP) && sel)
        cmp_o[c] <= wdata_i;
    end

    always_ff @(posedge clk_i) begin
      if (rst_i)
        ctl_o[c] <= '0;
      else if (wr_en_i && grp == GW'(G_CTL) && sel)
        ctl_o[c] <= chan_ctrl_t'(wdata_i[2:0]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      casc_o <= '0;
    else if (wr_en_i && grp == GW'(G_CAS) && idx == 2'd0)
      casc_o <= wdata_i[1:0];
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < N; c++) begin
      if (idx == 2'(c)) begin
        case (grp)
          GW'(G_CNT): rd_mux = cnt_i[c];
          GW'(G_CMP): rd_mux = cmp_o[c];
          GW'(G_CTL): rd_mux = W'(ctl_o[c]);
          default:    rd_mux = '0;
        endcase
      end
    end
    if (grp == GW'(G_CAS) && idx == 2'd0)
      rd_mux = W'(casc_o);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      rdata_o <= '0;
    else if (rd_en_i)
      rdata_o <= rd_mux;
  end
endmodule

// File: rtl/timer_link.sv
module timer_link
  import timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  chan_ctrl_t        ctl_i    [NCH],
  input  logic [1:0]        casc_i,
  input  logic [NCH-1:0]    tick_i,
  input  logic [NCH-1:0]    pend_i,
  input  logic [NCH-1:0]    rd_hit_i,
  input  logic [W-1:0]      cnt_i    [NCH],
  input  logic [W-1:0]      cmp_i    [NCH],
  output logic [NCH-1:0]    run_o,
  output logic [NCH-1:0]    hold_o,
  output logic [NCH-1:0]    step_o,
  output logic [NCH-1:0]    inc_o,
  output logic [NCH-1:0]    wrap_o,
  output logic [NCH-1:0]    match_o
);
  localparam logic [W-1:0] TOP = '1;

  logic j01, j12, run01, run12, hold01, hold12, eq01, eq12;
  logic [NCH-1:0] eq8, strobe, mode;

  always_comb begin
    j01 = casc_i[0];
    j12 = casc_i[1] & ~casc_i[0];   // pair (0,1) takes precedence
    for (int c = 0; c < NCH; c++) eq8[c] = (cnt_i[c] == cmp_i[c]);
    run01  = ctl_i[0].en & ctl_i[1].en;
    run12  = ctl_i[1].en & ctl_i[2].en;
    hold01 = rd_hit_i[0] | rd_hit_i[1];
    hold12 = rd_hit_i[1] | rd_hit_i[2];
    eq01   = eq8[0] & eq8[1];
    eq12   = eq8[1] & eq8[2];

    run_o[0]  = j01 ? run01 : ctl_i[0].en;
    run_o[1]  = j01 ? run01 : (j12 ? run12 : ctl_i[1].en);
    run_o[2]  = j12 ? run12 : ctl_i[2].en;
    hold_o[0] = j01 ? hold01 : rd_hit_i[0];
    hold_o[1] = j01 ? hold01 : (j12 ? hold12 : rd_hit_i[1]);
    hold_o[2] = j12 ? hold12 : rd_hit_i[2];

    for (int c = 0; c < NCH; c++)
      strobe[c] = (tick_i[c] | pend_i[c]) & ~hold_o[c] & run_o[c];

    // channel 0: single or lower byte of (0,1)
    step_o[0]  = strobe[0];
    inc_o[0]   = strobe[0];
    match_o[0] = j01 ? eq01 : eq8[0];
    mode[0]    = ctl_i[0].clr_mode;

    // channel 1: upper of (0,1), lower of (1,2), or single
    if (j01) begin
      step_o[1]  = strobe[0];
      inc_o[1]   = strobe[0] & (cnt_i[0] == TOP);
      match_o[1] = eq01;
      mode[1]    = ctl_i[0].clr_mode;
    end else begin
      step_o[1]  = strobe[1];
      inc_o[1]   = strobe[1];
      match_o[1] = j12 ? eq12 : eq8[1];
      mode[1]    = ctl_i[1].clr_mode;
    end

    // channel 2: upper of (1,2) or single
    if (j12) begin
      step_o[2]  = strobe[1];
      inc_o[2]   = strobe[1] & (cnt_i[1] == TOP);
      match_o[2] = eq12;
      mode[2]    = ctl_i[1].clr_mode;
    end else begin
      step_o[2]  = strobe[2];
      inc_o[2]   = strobe[2];
      match_o[2] = eq8[2];
      mode[2]    = ctl_i[2].clr_mode;
    end

    for (int c = 0; c < NCH; c++)
      wrap_o[c] = step_o[c] & match_o[c] & mode[c];
  end
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         run_i,
  input  logic         hold_i,
  input  logic         tick_i,
  input  logic         step_i,
  input  logic         inc_i,
  input  logic         wrap_i,
  input  logic         match_i,
  input  logic         pwm_i,
  output logic [W-1:0] cnt_o,
  output logic         pend_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i)
      cnt_o <= '0;
    else if (wrap_i)
      cnt_o <= '0;
    else if (inc_i)
      cnt_o <= cnt_o + 1'b1;
  end

  // a strobe that arrives during a counter read is kept for one cycle
  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i)
      pend_o <= 1'b0;
    else if (hold_i)
      pend_o <= pend_o | tick_i;
    else
      pend_o <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      irq_o <= 1'b0;
    else
      irq_o <= step_i & match_i & ~pwm_i;
  end

  AST_CLEAR_ON_DISABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> cnt_o == '0); // R3
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && inc_i && !wrap_i) |=> cnt_o == W'($past(cnt_o) + 1'b1)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_i |=> cnt_o == '0); // R4
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
    (hold_i && run_i) |=> cnt_o == $past(cnt_o)); // R11
endmodule

// File: rtl/casc_timer_bank.sv
module casc_timer_bank
  import timer_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [NCH-1:0] tick_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  output logic [NCH-1:0] irq_o
);
  logic [W-1:0]   cnt [NCH];
  logic [W-1:0]   cmp [NCH];
  chan_ctrl_t     ctl [NCH];
  logic [1:0]     casc;
  logic [NCH-1:0] rd_hit, pend, run, hold, step, inc, wrap, match;

  timer_regs #(.N(NCH), .W(W), .AW(AW)) i_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt), .rdata_o(rdata_o),
    .cmp_o(cmp), .ctl_o(ctl), .casc_o(casc), .rd_hit_o(rd_hit)
  );

  timer_link #(.W(W)) i_link (
    .ctl_i(ctl), .casc_i(casc), .tick_i(tick_i), .pend_i(pend),
    .rd_hit_i(rd_hit), .cnt_i(cnt), .cmp_i(cmp), .run_o(run),
    .hold_o(hold), .step_o(step), .inc_o(inc), .wrap_o(wrap), .match_o(match)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    timer_chan #(.W(W)) i_chan (
      .clk_i(clk_i), .rst_i(rst_i), .run_i(run[c]), .hold_i(hold[c]),
      .tick_i(tick_i[c]), .step_i(step[c]), .inc_i(inc[c]), .wrap_i(wrap[c]),
      .match_i(match[c]), .pwm_i(ctl[c].pwm), .cnt_o(cnt[c]),
      .pend_o(pend[c]), .irq_o(irq_o[c])
    );

    AST_PWM_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      ctl[c].pwm |=> !irq_o[c]); // R5
  end

  AST_PAIR_IRQ: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(casc[0] && !ctl[0].pwm && !ctl[1].pwm) && irq_o[0]) |-> irq_o[1]); // R7
endmodule

// File: tb/test_casc_timer_bank.sv
module test_casc_timer_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] tick = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] irq;

  int checks = 0, errors = 0;
  int icnt [3];
  int co01 = 0, co12 = 0;
  logic [7:0] d;

  localparam logic [3:0] CNT0 = 4'd0, CMP0 = 4'd4, CTL0 = 4'd8, CAS = 4'd12;

  always #10 clk = ~clk;

  casc_timer_bank i_casc_timer_bank (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0]  cmp;
    logic        clr;
    logic        pwm;
    logic [15:0] n;
    logic [7:0]  cnt;
    logic [7:0]  irqs;
  } vec_t;

  // channel 0 alone: compare, mode, pwm, strobes, expected count, expected irqs
  localparam vec_t VEC [8] = '{
    '{8'd10,  1'b0, 1'b0, 16'd5,   8'd5,  8'd0},
    '{8'd3,   1'b0, 1'b0, 16'd5,   8'd5,  8'd1},
    '{8'd3,   1'b1, 1'b0, 16'd5,   8'd1,  8'd1},
    '{8'd0,   1'b1, 1'b0, 16'd4,   8'd0,  8'd4},
    '{8'd255, 1'b0, 1'b0, 16'd256, 8'd0,  8'd1},
    '{8'd2,   1'b1, 1'b1, 16'd7,   8'd1,  8'd0},
    '{8'd2,   1'b1, 1'b0, 16'd7,   8'd1,  8'd2},
    '{8'd200, 1'b0, 1'b0, 16'd300, 8'd44, 8'd1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clr_irq();
    for (int k = 0; k < 3; k++) icnt[k] = 0;
    co01 = 0; co12 = 0;
  endtask

  task automatic tally();
    for (int k = 0; k < 3; k++) if (irq[k]) icnt[k]++;
    if (irq[0] && irq[1]) co01++;
    if (irq[1] && irq[2]) co12++;
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = m;
      @(posedge clk); #1 tally();
    end
    @(negedge clk); tick = '0;
    @(posedge clk); #1 tally();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr_irq();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 irq", int'(irq), 0);
    for (int c = 0; c < 3; c++) begin
      rd(4'(c), d);     check("R1 counter", d, 0);
      rd(4'(8 + c), d); check("R1 control", d, 0);
    end
    rd(CAS, d); check("R1 cascade", d, 0);

    // R2 R4 R5 vector walk on channel 0
    foreach (VEC[i]) begin
      wr(CTL0, 8'h00);
      wr(CMP0, VEC[i].cmp);
      wr(CTL0, {5'b0, VEC[i].pwm, VEC[i].clr, 1'b1});
      clr_irq();
      pulse(3'b001, int'(VEC[i].n));
      rd(CNT0, d);
      check($sformatf("R2/R4 vector %0d count", i), d, VEC[i].cnt);
      check($sformatf("R4/R5 vector %0d irqs", i), icnt[0], VEC[i].irqs);
    end

    // R6 single-cycle pulse
    wr(CTL0, 8'h00); wr(CMP0, 8'd0); wr(CTL0, 8'h03);
    @(negedge clk); tick = 3'b001;
    @(posedge clk); #1 check("R6 irq high", irq[0], 1);
    @(negedge clk); tick = '0;
    @(posedge clk); #1 check("R6 irq low next", irq[0], 0);

    // R12 compare rewrite while counting
    wr(CTL0, 8'h00); wr(CMP0, 8'd100); wr(CTL0, 8'h03);
    pulse(3'b001, 5);
    wr(CMP0, 8'd6);
    clr_irq();
    pulse(3'b001, 2);
    rd(CNT0, d); check("R12 count after new compare", d, 0);
    check("R12 irq", icnt[0], 1);

    // R3 disable clears
    wr(CTL0, 8'h00);
    wr(4'd9, 8'h01);
    pulse(3'b010, 5);
    rd(4'd1, d); check("R3 running count", d, 5);
    wr(4'd9, 8'h00);
    rd(4'd1, d); check("R3 cleared", d, 0);

    // R2 disabled channel ignores strobes
    pulse(3'b100, 4);
    rd(4'd2, d); check("R2 disabled stays", d, 0);

    // R7 cascade (0,1), compare 0102h, clear-and-start
    wr(CAS, 8'h01); wr(CMP0, 8'h02); wr(4'd5, 8'h01);
    wr(4'd9, 8'h01); wr(CTL0, 8'h03);
    clr_irq();
    pulse(3'b011, 256);
    rd(CNT0, d);  check("R7 low byte rolled", d, 0);
    rd(4'd1, d);  check("R7 upper carry", d, 1);
    check("R7 no early irq", icnt[0], 0);
    pulse(3'b011, 44);
    rd(CNT0, d);  check("R7 low after 16-bit clear", d, 41);
    rd(4'd1, d);  check("R7 upper after 16-bit clear", d, 0);
    check("R7 irq0", icnt[0], 1);
    check("R7 irq1", icnt[1], 1);
    check("R7 together", co01, 1);

    // R8 clearing the upper enable clears both bytes
    wr(4'd9, 8'h00);
    rd(CNT0, d); check("R8 low byte cleared", d, 0);
    rd(4'd1, d); check("R8 upper byte cleared", d, 0);

    // R9 both cascade bits: (0,1) wins, channel 2 alone
    wr(CAS, 8'h03); wr(CMP0, 8'hFF); wr(4'd5, 8'hFF); wr(4'd6, 8'h50);
    wr(CTL0, 8'h01); wr(4'd9, 8'h01); wr(4'd10, 8'h01);
    pulse(3'b111, 3);
    rd(CNT0, d); check("R9 pair low", d, 3);
    rd(4'd1, d); check("R9 pair upper", d, 0);
    rd(4'd2, d); check("R9 channel 2 alone", d, 3);

    // R10 cascade (1,2), compare 0100h, free running
    wr(CTL0, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00);
    wr(CAS, 8'h02); wr(4'd5, 8'h00); wr(4'd6, 8'h01);
    wr(4'd9, 8'h01); wr(4'd10, 8'h01);
    clr_irq();
    pulse(3'b110, 257);
    rd(4'd1, d); check("R10 low byte", d, 1);
    rd(4'd2, d); check("R10 upper byte", d, 1);
    check("R10 irq1", icnt[1], 1);
    check("R10 irq2", icnt[2], 1);
    check("R10 together", co12, 1);
    check("R10 channel 0 idle", icnt[0], 0);

    // R11 read during a strobe
    wr(4'd9, 8'h00); wr(4'd10, 8'h00); wr(CAS, 8'h00);
    wr(CMP0, 8'hFF); wr(CTL0, 8'h01);
    pulse(3'b001, 3);
    @(negedge clk); rd_en = 1'b1; addr = CNT0; tick = 3'b001;
    @(posedge clk); #1 check("R11 snapshot", rdata, 3);
    @(negedge clk); rd_en = 1'b0; tick = '0;
    rd(CNT0, d); check("R11 delayed strobe counted", d, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule